// File: doc/BRIEF.md
# Dual-Mode Serial Voice and Control Port

This block moves 8-bit voice samples and control bytes between a register file and a single-wire serial link. A mode input picks one of two framings. In strobe mode, each rising edge of an active-high strobe opens one 8-bit slot. The slot sends one byte and receives one byte, and its bit period comes from a two-bit rate select. In frame mode, an active-low frame pulse starts a frame of 32 eight-bit channels at a fixed rate of two clocks per bit. Channel 0 carries two control bits (the D channel). Channel 1 carries a control byte (the C channel). Channel 2 carries the voice byte.

The D channel delivers only two bits per frame, so the receiver builds a byte from four consecutive frames and pulses a ready interrupt when the byte is complete. The transmitter sends the register-file byte the same way, two bits per frame. Received C-channel bytes are captured every frame. Transmitted C-channel bits come from a local register that resets to all ones. The output is driven only during bits the port owns and is released to high impedance at all other times.

Top module: `sport_top`

## Requirements
- R1: `mode`=1 selects frame mode and `mode`=0 selects strobe mode. A change of `mode` aborts any slot or frame in progress, and the output stays released until the next strobe edge or frame pulse.
- R2: In strobe mode, a rising edge of `stb` (sampled on `clk`) starts an 8-bit slot. `b_tx` is shifted out MSB first. `sdi` is sampled at the last clock of each bit. After the eighth bit, `b_rx` holds the received byte, with the first bit as its MSB, and `b_vld` pulses for one clock.
- R3: In strobe mode, each bit lasts 16, 8, 4 or 2 clocks for `rate_sel` = 0, 1, 2 or 3, so the output is driven for 8 times that many clocks per slot.
- R4: In frame mode, `fp_n` sampled low on a clock edge starts bit 0 of channel 0. Every bit lasts 2 clocks whatever `rate_sel` holds, and a frame has 256 bits (channel = bit index / 8).
- R5: In frame mode with `c_en`=1, channel 1 sends the C register MSB first. The C register resets to 8'hFF and loads `c_wdata` when `c_wr`=1. With `c_en`=0, channel 1 is not driven.
- R6: The byte received in channel 1 is captured into `c_rx` every frame, whatever `c_en` holds, and `c_rx` never changes in strobe mode.
- R7: With `d_en`=1 in frame mode, bits 0 and 1 of channel 0 carry D bits. Frame group g (0..3) sends `d_tx` bits 7-2g and 6-2g. The receiver builds `d_rx` from the same positions over four frames. `d_irq` pulses for one clock after the fourth frame. `d_en`=0 releases channel 0 and returns the group count to 0.
- R8: In frame mode, channel 2 sends `b_tx` and captures into `b_rx` with a `b_vld` pulse. `b_vld` and `d_irq` are never high in the same clock.
- R9: `sdo_oe` is low, and `sdo` is high impedance, outside a slot, in unused channels and in bits 2..7 of channel 0.
- R10: While `rst_n` is low, all outputs are 0 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock (twice the bit rate in frame mode) |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 1 frame mode, 0 strobe mode |
| rate_sel | input | 2 | Strobe-mode bit-period select |
| stb | input | 1 | Active-high slot strobe (strobe mode) |
| fp_n | input | 1 | Active-low frame pulse (frame mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, high impedance when not driven |
| sdo_oe | output | 1 | High while `sdo` is driven |
| c_en | input | 1 | C-channel transmit enable |
| d_en | input | 1 | D-channel enable |
| c_wr | input | 1 | Load strobe for the C transmit register |
| c_wdata | input | 8 | Value loaded into the C transmit register |
| d_tx | input | 8 | D byte sent over four frames |
| b_tx | input | 8 | Voice byte to send |
| b_rx | output | 8 | Last received voice byte |
| b_vld | output | 1 | One-clock pulse when `b_rx` is updated |
| c_rx | output | 8 | Last received C-channel byte |
| d_rx | output | 8 | Last completed D byte |
| d_irq | output | 1 | One-clock pulse when a D byte is complete |

## Verification
The hardest state to reach is the D-channel group boundary, because a byte appears only once in four frames and its alignment depends on the history of `d_en`. The stimulus runs seven frames with the enable held high, so one byte completes and the count is left in mid-group. It then drops `d_en` for one frame and runs four more frames, so the second interrupt can only come from a group count that was cleared. A behavioural model, driven by random line data, predicts every output on every clock, including the mid-group state of the D bits on the wire.

// File: rtl/sport_pkg.sv
// Shared constants and types for the dual-mode serial port.
package sport_pkg;
    typedef enum logic {MODE_STROBE = 1'b0, MODE_FRAME = 1'b1} port_mode_e;
    localparam int SLOT_W   = 8;                 // bits per channel / slot
    localparam int POS_W    = $clog2(SLOT_W);    // bit-in-slot index width
    localparam int CH_D     = 0;                 // channel carrying D bits
    localparam int CH_C     = 1;                 // control byte channel
    localparam int D_BITS   = 2;                 // D bits per frame
    localparam int D_GROUPS = SLOT_W / D_BITS;   // frames per D byte
    localparam int DG_W     = $clog2(D_GROUPS);
endpackage

// File: rtl/sport_timing.sv
// Bit timing for the serial port: bit-phase divider and bit index.
// Assumes a single clock; the bit period is TDM_DIV in frame mode and
// SLOW_DIV >> rate_sel in strobe mode. A strobe slot ends after SLOT_W bits.
module sport_timing
    import sport_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int TDM_DIV  = 2,
    parameter int SLOW_DIV = 16,
    localparam int BCW     = $clog2(NUM_CH * SLOT_W),
    localparam int DCW     = $clog2(SLOW_DIV) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode,
    input  logic [1:0]     rate_sel,
    input  logic           stb,
    input  logic           fp_n,
    output logic           act,
    output logic           sample,
    output port_mode_e     mode_q,
    output logic [BCW-1:0] bcnt
);
    logic [DCW-1:0] per;
    logic [DCW-1:0] dcnt;
    logic           stb_q;
    logic           last_ph;
    logic           same;
    logic           start;

    // Bit period for the current mode and rate.
    always_comb begin
        if (mode_q == MODE_FRAME) per = DCW'(TDM_DIV);
        else                      per = DCW'(SLOW_DIV >> rate_sel);
    end

    assign last_ph = (dcnt >= per - 1'b1);
    assign same    = (mode == mode_q);
    assign start   = (mode_q == MODE_FRAME) ? !fp_n : (stb && !stb_q);
    assign sample  = act && last_ph && same;

    // Registered copies of the mode and strobe for edge and change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STROBE;
            stb_q  <= 1'b0;
        end else begin
            mode_q <= port_mode_e'(mode);
            stb_q  <= stb;
        end
    end

    // Phase and bit counters: restart on strobe/frame, stop at slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= 1'b0;
            dcnt <= '0;
            bcnt <= '0;
        end else if (!same) begin
            act  <= 1'b0;
            dcnt <= '0;
            bcnt <= '0;
        end else if (start) begin
            act  <= 1'b1;
            dcnt <= '0;
            bcnt <= '0;
        end else if (act) begin
            if (last_ph) begin
                dcnt <= '0;
                if (mode_q == MODE_STROBE && bcnt == BCW'(SLOT_W - 1)) begin
                    act  <= 1'b0;
                    bcnt <= '0;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sport_rx.sv
// Receive side: shifts sdi in MSB first and steers bytes to the voice,
// C and D outputs. Assumes sample marks the last clock of each bit.
module sport_rx
    import sport_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int B_CH   = 2,
    localparam int BCW   = $clog2(NUM_CH * SLOT_W),
    localparam int CHW   = BCW - POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  port_mode_e        mode_q,
    input  logic [BCW-1:0]    bcnt,
    input  logic              sdi,
    input  logic              d_en,
    output logic [SLOT_W-1:0] b_rx,
    output logic              b_vld,
    output logic [SLOT_W-1:0] c_rx,
    output logic [SLOT_W-1:0] d_rx,
    output logic              d_irq,
    output logic [DG_W-1:0]   fgrp
);
    logic [SLOT_W-2:0] rx_sh;
    logic [SLOT_W-1:0] byte_in;
    logic [SLOT_W-3:0] d_sh;
    logic [SLOT_W-1:0] d_next;
    logic [CHW-1:0]    ch;
    logic [POS_W-1:0]  pos;
    logic              slot_end;
    logic              frame_m;

    assign ch       = bcnt[BCW-1:POS_W];
    assign pos      = bcnt[POS_W-1:0];
    assign byte_in  = {rx_sh, sdi};
    assign d_next   = {d_sh, rx_sh[0], sdi};
    assign slot_end = sample && (pos == POS_W'(SLOT_W - 1));
    assign frame_m  = (mode_q == MODE_FRAME);

    // Serial shift register for incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_sh <= '0;
        else if (sample) rx_sh <= byte_in[SLOT_W-2:0];
    end

    // Voice byte capture: the strobe slot, or the voice channel in a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_rx  <= '0;
            b_vld <= 1'b0;
        end else begin
            b_vld <= 1'b0;
            if (slot_end && (!frame_m || ch == CHW'(B_CH))) begin
                b_rx  <= byte_in;
                b_vld <= 1'b1;
            end
        end
    end

    // C-channel capture, independent of the transmit enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   c_rx <= '0;
        else if (slot_end && frame_m && ch == CHW'(CH_C)) c_rx <= byte_in;
    end

    // D-bit collection over four frames with a ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_sh  <= '0;
            d_rx  <= '0;
            d_irq <= 1'b0;
            fgrp  <= '0;
        end else begin
            d_irq <= 1'b0;
            if (!d_en) begin
                fgrp <= '0;
            end else if (sample && frame_m && ch == CHW'(CH_D) &&
                         pos == POS_W'(D_BITS - 1)) begin
                d_sh <= d_next[SLOT_W-3:0];
                fgrp <= fgrp + 1'b1;
                if (fgrp == DG_W'(D_GROUPS - 1)) begin
                    d_rx  <= d_next;
                    d_irq <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sport_tx.sv
// Transmit side: selects the output bit and drive enable from the current
// bit index. Purely combinational; assumes the timing state is registered.
module sport_tx
    import sport_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int B_CH   = 2,
    localparam int BCW   = $clog2(NUM_CH * SLOT_W),
    localparam int CHW   = BCW - POS_W
) (
    input  logic              act,
    input  port_mode_e        mode_q,
    input  logic [BCW-1:0]    bcnt,
    input  logic [DG_W-1:0]   fgrp,
    input  logic              d_en,
    input  logic              c_en,
    input  logic [SLOT_W-1:0] d_tx,
    input  logic [SLOT_W-1:0] c_tx,
    input  logic [SLOT_W-1:0] b_tx,
    output logic              oe,
    output logic              dbit
);
    logic [CHW-1:0]   ch;
    logic [POS_W-1:0] msb_idx;
    logic [POS_W-1:0] d_idx;

    assign ch      = bcnt[BCW-1:POS_W];
    assign msb_idx = ~bcnt[POS_W-1:0];
    assign d_idx   = {~fgrp, ~bcnt[0]};

    // Output bit and enable for the slot or channel now on the wire.
    always_comb begin
        oe   = 1'b0;
        dbit = 1'b0;
        if (act) begin
            if (mode_q == MODE_STROBE) begin
                oe   = 1'b1;
                dbit = b_tx[msb_idx];
            end else if (ch == CHW'(CH_D)) begin
                if (d_en && bcnt[POS_W-1:0] < POS_W'(D_BITS)) begin
                    oe   = 1'b1;
                    dbit = d_tx[d_idx];
                end
            end else if (ch == CHW'(CH_C)) begin
                oe   = c_en;
                dbit = c_tx[msb_idx];
            end else if (ch == CHW'(B_CH)) begin
                oe   = 1'b1;
                dbit = b_tx[msb_idx];
            end
        end
    end
endmodule

// File: rtl/sport_top.sv
// Dual-mode serial port top: strobe slot or multi-channel frame.
// Assumes all inputs are synchronous to clk; sdo is released when not driven.
module sport_top
    import sport_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int B_CH     = 2,
    parameter int TDM_DIV  = 2,
    parameter int SLOW_DIV = 16,
    localparam int BCW     = $clog2(NUM_CH * SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic [1:0]        rate_sel,
    input  logic              stb,
    input  logic              fp_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              c_en,
    input  logic              d_en,
    input  logic              c_wr,
    input  logic [SLOT_W-1:0] c_wdata,
    input  logic [SLOT_W-1:0] d_tx,
    input  logic [SLOT_W-1:0] b_tx,
    output logic [SLOT_W-1:0] b_rx,
    output logic              b_vld,
    output logic [SLOT_W-1:0] c_rx,
    output logic [SLOT_W-1:0] d_rx,
    output logic              d_irq
);
    logic              act;
    logic              sample;
    port_mode_e        mode_q;
    logic [BCW-1:0]    bcnt;
    logic [DG_W-1:0]   fgrp;
    logic [SLOT_W-1:0] c_reg;
    logic              tx_bit;

    // C transmit register, all ones out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    c_reg <= '1;
        else if (c_wr) c_reg <= c_wdata;
    end

    sport_timing #(.NUM_CH(NUM_CH), .TDM_DIV(TDM_DIV), .SLOW_DIV(SLOW_DIV)) u_tim (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rate_sel(rate_sel),
        .stb(stb), .fp_n(fp_n), .act(act), .sample(sample),
        .mode_q(mode_q), .bcnt(bcnt)
    );

    sport_rx #(.NUM_CH(NUM_CH), .B_CH(B_CH)) u_rx (
        .clk(clk), .rst_n(rst_n), .sample(sample), .mode_q(mode_q),
        .bcnt(bcnt), .sdi(sdi), .d_en(d_en), .b_rx(b_rx), .b_vld(b_vld),
        .c_rx(c_rx), .d_rx(d_rx), .d_irq(d_irq), .fgrp(fgrp)
    );

    sport_tx #(.NUM_CH(NUM_CH), .B_CH(B_CH)) u_tx (
        .act(act), .mode_q(mode_q), .bcnt(bcnt), .fgrp(fgrp),
        .d_en(d_en), .c_en(c_en), .d_tx(d_tx), .c_tx(c_reg), .b_tx(b_tx),
        .oe(sdo_oe), .dbit(tx_bit)
    );

    assign sdo = sdo_oe ? tx_bit : 1'bz;
endmodule

// File: rtl/sport_chk.sv
// Temporal checks for sport_top, bound to every instance.
module sport_chk #(
    parameter int BCW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mode,
    input logic           c_en,
    input logic           d_irq,
    input logic           b_vld,
    input logic [7:0]     c_rx,
    input logic           sdo_oe,
    input logic           act,
    input logic           mode_q,
    input logic [BCW-1:0] bcnt
);
    // R7
    irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_irq |-> $past(mode));
    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_irq |=> !d_irq);
    // R2
    bvld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_vld |=> !b_vld);
    // R8
    vld_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_vld && d_irq));
    // R6
    crx_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_rx) |-> $past(mode));
    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> !sdo_oe);
    // R5
    c_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && act && !c_en && bcnt[BCW-1:3] == 1) |-> !sdo_oe);
endmodule

bind sport_top sport_chk #(.BCW(BCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .c_en(c_en), .d_irq(d_irq),
    .b_vld(b_vld), .c_rx(c_rx), .sdo_oe(sdo_oe), .act(act),
    .mode_q(mode_q), .bcnt(bcnt)
);

// File: tb/sim_sport_top.sv
// Bench: behavioural per-clock model of sport_top, compared every clock.
module sim_sport_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       stb = 1'b0;
    logic       fp_n = 1'b1;
    logic       sdi = 1'b0;
    wire        sdo;
    logic       sdo_oe;
    logic       c_en = 1'b0;
    logic       d_en = 1'b0;
    logic       c_wr = 1'b0;
    logic [7:0] c_wdata = 8'h00;
    logic [7:0] d_tx = 8'h00;
    logic [7:0] b_tx = 8'h00;
    logic [7:0] b_rx, c_rx, d_rx;
    logic       b_vld, d_irq;

    always #4 clk = ~clk;

    sport_top u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rate_sel(rate_sel),
        .stb(stb), .fp_n(fp_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .c_en(c_en), .d_en(d_en), .c_wr(c_wr), .c_wdata(c_wdata),
        .d_tx(d_tx), .b_tx(b_tx), .b_rx(b_rx), .b_vld(b_vld),
        .c_rx(c_rx), .d_rx(d_rx), .d_irq(d_irq)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R10";
    bit    done = 1'b0;
    int    irq_seen = 0;

    task automatic check(input bit ok, input string req, input int actv, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, actv, expv);
        end
    endtask

    // Random line data, changed away from the sampling edge.
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sdi  <= lfsr[0];
    end

    // Behavioural model state.
    int m_act = 0, m_t = 0, m_modeq = 0, m_stbq = 0, m_c = 255;
    int m_rx = 0, m_dsh = 0, m_fg = 0;
    int e_brx = 0, e_bvld = 0, e_crx = 0, e_drx = 0, e_irq = 0;

    always @(posedge clk) begin : model
        int per, k, ch, pos;
        bit smp;
        if (!rst_n) begin
            m_act = 0; m_t = 0; m_modeq = 0; m_stbq = 0; m_c = 255;
            m_rx = 0; m_dsh = 0; m_fg = 0;
            e_brx = 0; e_bvld = 0; e_crx = 0; e_drx = 0; e_irq = 0;
        end else begin
            per = (m_modeq != 0) ? 2 : (16 >> rate_sel);
            smp = (m_act != 0) && (int'(mode) == m_modeq) && ((m_t % per) == per - 1);
            e_bvld = 0;
            e_irq  = 0;
            if (smp) begin
                k   = m_t / per;
                ch  = k / 8;
                pos = k % 8;
                m_rx = ((m_rx << 1) | int'(sdi)) & 255;
                if (m_modeq == 0) begin
                    if (pos == 7) begin e_brx = m_rx; e_bvld = 1; end
                end else begin
                    if (pos == 7 && ch == 2) begin e_brx = m_rx; e_bvld = 1; end
                    if (pos == 7 && ch == 1) e_crx = m_rx;
                    if (ch == 0 && pos == 1 && d_en) begin
                        m_dsh = ((m_dsh << 2) | (m_rx & 3)) & 255;
                        if (m_fg == 3) begin e_drx = m_dsh; e_irq = 1; end
                        m_fg = (m_fg + 1) % 4;
                    end
                end
            end
            if (!d_en) m_fg = 0;
            if (int'(mode) != m_modeq) begin
                m_act = 0; m_t = 0;
            end else if ((m_modeq != 0) ? !fp_n : (stb && m_stbq == 0)) begin
                m_act = 1; m_t = 0;
            end else if (m_act != 0) begin
                m_t++;
                if (m_modeq == 0 && m_t == 8 * per) begin m_act = 0; m_t = 0; end
                else if (m_modeq != 0 && m_t == 512) m_t = 0;
            end
            m_modeq = int'(mode);
            m_stbq  = int'(stb);
            if (c_wr) m_c = int'(c_wdata);
        end
    end

    // Per-clock comparison, 2 ns after the edge.
    always @(posedge clk) begin : cmp
        int per, k, ch, pos, eoe, ebit;
        #2;
        if (!done) begin
            per = (m_modeq != 0) ? 2 : (16 >> rate_sel);
            k = m_t / per; ch = k / 8; pos = k % 8;
            eoe = 0; ebit = 0;
            if (m_act != 0) begin
                if (m_modeq == 0) begin eoe = 1; ebit = int'(b_tx[7-pos]); end
                else if (ch == 0) begin
                    if (d_en && pos < 2) begin eoe = 1; ebit = int'(d_tx[7-2*m_fg-pos]); end
                end else if (ch == 1) begin eoe = int'(c_en); ebit = (m_c >> (7 - pos)) & 1; end
                else if (ch == 2) begin eoe = 1; ebit = int'(b_tx[7-pos]); end
            end
            check(int'(sdo_oe) == eoe, {tag, " R9 sdo_oe"}, int'(sdo_oe), eoe);
            if (eoe != 0) check(int'(sdo) == ebit, {tag, " sdo"}, int'(sdo), ebit);
            check(int'(b_rx) == e_brx && int'(b_vld) == e_bvld, {tag, " R2 R8 voice"},
                  int'(b_rx) * 2 + int'(b_vld), e_brx * 2 + e_bvld);
            check(int'(c_rx) == e_crx, {tag, " R6 c_rx"}, int'(c_rx), e_crx);
            check(int'(d_rx) == e_drx && int'(d_irq) == e_irq, {tag, " R7 d"},
                  int'(d_rx) * 2 + int'(d_irq), e_drx * 2 + e_irq);
            if (d_irq) irq_seen++;
        end
    end

    task automatic strobe_slot(input int r);
        int per, cnt;
        per = 16 >> r;
        cnt = 0;
        @(negedge clk) rate_sel = 2'(r);
        @(negedge clk) stb = 1'b1;
        for (int i = 0; i < 8 * per + 4; i++) begin
            @(negedge clk);
            if (sdo_oe) cnt++;
            if (i == 2) stb = 1'b0;
        end
        // R3: driven for 8 bit periods
        check(cnt == 8 * per, "R3 slot length", cnt, 8 * per);
    endtask

    task automatic frame();
        @(negedge clk) fp_n = 1'b0;
        @(negedge clk) fp_n = 1'b1;
        repeat (510) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset values
        check(sdo_oe == 1'b0 && b_rx == 0 && c_rx == 0 && d_rx == 0 && !b_vld && !d_irq,
              "R10 reset", int'(sdo_oe), 0);
        rst_n = 1'b1;
        tag = "R2 R3";
        b_tx = 8'hA5;
        for (int r = 0; r < 4; r++) strobe_slot(r);
        b_tx = 8'h4E;
        strobe_slot(1);
        tag = "R1 R4 R5 R8";
        @(negedge clk) mode = 1'b1;
        c_en = 1'b1; d_en = 1'b1; d_tx = 8'h3C; b_tx = 8'h96; rate_sel = 2'd0;
        repeat (3) @(negedge clk);
        // R9: frame mode idle before first pulse
        check(sdo_oe == 1'b0, "R9 idle before frame", int'(sdo_oe), 0);
        for (int f = 0; f < 5; f++) frame();
        tag = "R5 write";
        @(negedge clk) begin c_wr = 1'b1; c_wdata = 8'h5A; end
        @(negedge clk) c_wr = 1'b0;
        for (int f = 0; f < 2; f++) frame();
        tag = "R7 regroup";
        d_en = 1'b0;
        frame();
        tag = "R4 R6 R7";
        d_en = 1'b1; c_en = 1'b0; rate_sel = 2'd3; d_tx = 8'hC9;
        for (int f = 0; f < 4; f++) frame();
        repeat (4) @(negedge clk);
        // R7: one byte per four-frame group, group reset by the enable
        check(irq_seen == 2, "R7 irq count", irq_seen, 2);
        tag = "R1 back";
        @(negedge clk) mode = 1'b0;
        repeat (3) @(negedge clk);
        // R1: mode change releases the line
        check(sdo_oe == 1'b0, "R1 release", int'(sdo_oe), 0);
        b_tx = 8'h17;
        strobe_slot(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule